// File: doc/BRIEF.md
# Glitch-Free Clock Output Router

This block drives two output pads of a clock synthesizer. The main pad carries the synthesized clock. The auxiliary pad carries one of three things, chosen by a two-bit selector: the reference clock, a second copy of the synthesized clock, or an unlock indicator. Each pad has its own disable bit. When a pad is disabled, its output-enable goes low and the pad floats.

While the loop is unlocked, both clock paths are blanked to a steady low. An override bit can pass the clock through regardless of lock. Nothing is driven onto the clock paths until the configuration reports a valid ratio. The block makes every clock-path change on a whole-period boundary. This covers enabling, disabling, blanking, unblanking and switching between the two clock sources. Each gate enable is resynchronized into the domain of the clock it gates and updated only while that clock is low. A change of source stops the old clock before the new one is released.

Top module: `crt_clk_router`

## Requirements
- R1: While `ratio_ok` is 0, `main_pin` and `aux_pin` stay low, in every selector setting.
- R2: With `ratio_ok`=1, `pll_locked`=1 and `main_off`=0, `main_pin` follows `syn_clk` at full rate and `main_oe` is 1.
- R3: With `unlock_pass`=0 and `pll_locked`=0, both clock paths are held low. With `unlock_pass`=1 the clocks run whatever the lock state. The pad enables are not affected by lock.
- R4: `main_off`=1 drives `main_oe` to 0. `aux_off`=1 drives `aux_oe` to 0 for every selector code. Clearing a disable bit restores the enable.
- R5: `aux_src`=2'b00 routes `ref_clk` to `aux_pin`. `aux_src`=2'b10 routes a copy of `syn_clk` to `aux_pin`.
- R6: With `aux_src`=2'b11 and `ind_open_drain`=0, the indicator is push-pull: `aux_oe`=1, and `aux_pin` is 1 when unlocked and 0 when locked.
- R7: With `aux_src`=2'b11 and `ind_open_drain`=1, the indicator is open-drain: `aux_pin`=0 with `aux_oe`=1 when unlocked, and `aux_oe`=0 when locked. `ind_open_drain` has no effect on the clock sources.
- R8: `aux_src`=2'b01 is reserved and drives `aux_pin` low.
- R9: While a clock source is selected, every driven high pulse on either pad lasts exactly half a period of its source clock, and every low interval lasts at least half a period. This holds across enable, disable, blanking and source changes between 2'b00 and 2'b10.
- R10: The two auxiliary clock gates are never open at the same time. After a source change, the auxiliary pulses match the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| syn_clk | input | 1 | Synthesized clock |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released separately into each domain |
| pll_locked | input | 1 | Loop lock flag, asynchronous |
| ratio_ok | input | 1 | Configuration holds a valid ratio |
| unlock_pass | input | 1 | Pass clocks while unlocked |
| main_off | input | 1 | Float the main pad |
| aux_off | input | 1 | Float the auxiliary pad |
| aux_src | input | 2 | Auxiliary source: 00 reference, 01 reserved, 10 synthesized, 11 unlock indicator |
| ind_open_drain | input | 1 | Indicator driver: 0 push-pull, 1 open-drain |
| main_pin | output | 1 | Main pad value |
| main_oe | output | 1 | Main pad output-enable |
| aux_pin | output | 1 | Auxiliary pad value |
| aux_oe | output | 1 | Auxiliary pad output-enable |

## Verification
The assertions assume that the control inputs change asynchronously but slowly. Each setting is assumed to be held for far longer than the resynchronizer depth in both clock domains, so that a change of source completes before the next one begins. The stimulus respects this by changing one control at a time, each change separated by a settling gap of many periods of the slower clock. The monitor for auxiliary pulse widths is paused whenever the indicator code is entered or left, because no glitch-free guarantee covers that case.

// File: rtl/crt_clk_router_pkg.sv
`timescale 1ns/1ps
package crt_clk_router_pkg;

  typedef enum logic [1:0] {
    AUX_SRC_REF  = 2'b00,
    AUX_SRC_RSVD = 2'b01,
    AUX_SRC_SYN  = 2'b10,
    AUX_SRC_IND  = 2'b11
  } aux_src_e;

  typedef struct packed {
    logic pin;
    logic drive;
  } pad_t;

  // Clock paths may run only with a valid ratio and lock (or the override).
  function automatic logic clk_pass(input logic valid, input logic locked,
                                    input logic override);
    return valid & (locked | override);
  endfunction

  // Indicator pad: low until the ratio is valid, then push-pull or open-drain.
  function automatic pad_t lock_indicator(input logic valid, input logic locked,
                                          input logic open_drain);
    pad_t p;
    if (!valid) begin
      p.pin   = 1'b0;
      p.drive = 1'b1;
    end else if (open_drain) begin
      p.pin   = 1'b0;
      p.drive = ~locked;
    end else begin
      p.pin   = ~locked;
      p.drive = 1'b1;
    end
    return p;
  endfunction

  // Enable rises at once; it falls only after the gated path has gone idle.
  function automatic logic oe_next(input logic cur, input logic off_req,
                                   input logic path_busy);
    if (!off_req)       return 1'b1;
    else if (!path_busy) return 1'b0;
    else                return cur;
  endfunction

endpackage

// File: rtl/crt_sync.sv
`timescale 1ns/1ps
module crt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/crt_clk_gate.sv
`timescale 1ns/1ps
module crt_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,     // already in the clk domain
  output logic gclk,
  output logic run,    // gate state, changes only while clk is low
  output logic busy    // registered en|run, safe to resynchronize
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= en | run;
  end

  assign gclk = clk & run;
endmodule

// File: rtl/crt_aux_path.sv
`timescale 1ns/1ps
module crt_aux_path #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic syn_clk,
  input  logic ref_rst_n,
  input  logic syn_rst_n,
  input  logic want_ref_raw,
  input  logic want_syn_raw,
  input  logic aux_off,
  output logic aux_clk,
  output logic aux_oe_q
);
  import crt_clk_router_pkg::*;

  localparam int XW = 3;

  logic [XW-1:0] ref_side_q, syn_side_q;
  logic want_ref_r, oe_r, syn_busy_r;
  logic want_syn_s, off_s, ref_busy_s;
  logic ref_en, syn_en;
  logic ref_g, syn_g, ref_run, syn_run, ref_busy, syn_busy;

  crt_sync #(.STAGES(SYNC_STAGES), .WIDTH(XW)) u_to_ref (
    .clk(ref_clk), .rst_n(ref_rst_n),
    .d({want_ref_raw, aux_oe_q, syn_busy}), .q(ref_side_q));
  assign {want_ref_r, oe_r, syn_busy_r} = ref_side_q;

  crt_sync #(.STAGES(SYNC_STAGES), .WIDTH(XW)) u_to_syn (
    .clk(syn_clk), .rst_n(syn_rst_n),
    .d({want_syn_raw, aux_off, ref_busy}), .q(syn_side_q));
  assign {want_syn_s, off_s, ref_busy_s} = syn_side_q;

  // Break before make: each side waits for the other to report idle.
  assign ref_en = want_ref_r & oe_r & ~syn_busy_r;
  assign syn_en = want_syn_s & aux_oe_q & ~ref_busy_s;

  crt_clk_gate u_ref_gate (.clk(ref_clk), .rst_n(ref_rst_n), .en(ref_en),
                           .gclk(ref_g), .run(ref_run), .busy(ref_busy));
  crt_clk_gate u_syn_gate (.clk(syn_clk), .rst_n(syn_rst_n), .en(syn_en),
                           .gclk(syn_g), .run(syn_run), .busy(syn_busy));

  always_ff @(posedge syn_clk or negedge syn_rst_n) begin
    if (!syn_rst_n) aux_oe_q <= 1'b0;
    else            aux_oe_q <= oe_next(aux_oe_q, off_s, syn_busy | ref_busy_s);
  end

  assign aux_clk = ref_g | syn_g;

  // R10: the two auxiliary gates never conduct together
  a_r10_single_source: assert property (@(posedge syn_clk) disable iff (!syn_rst_n)
    $onehot0({ref_run, syn_run}));

  // R4 / R9: the auxiliary enable falls only once both gates are closed
  a_r4_aux_oe_after_close: assert property (@(posedge syn_clk) disable iff (!syn_rst_n)
    $fell(aux_oe_q) |-> (!ref_run && !syn_run));
endmodule

// File: rtl/crt_clk_router.sv
`timescale 1ns/1ps
module crt_clk_router #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       syn_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       pll_locked,
  input  logic       ratio_ok,
  input  logic       unlock_pass,
  input  logic       main_off,
  input  logic       aux_off,
  input  logic [1:0] aux_src,
  input  logic       ind_open_drain,
  output logic       main_pin,
  output logic       main_oe,
  output logic       aux_pin,
  output logic       aux_oe
);
  import crt_clk_router_pkg::*;

  localparam int MW = 4;

  logic syn_rst_n, ref_rst_n;
  logic [MW-1:0] main_side_q;
  logic valid_s, lock_s, ovr_s, moff_s;
  logic main_oe_q, main_en, main_run, main_busy;
  logic raw_pass, want_ref_raw, want_syn_raw;
  logic aux_clk, aux_oe_q;
  pad_t ind;

  // Per-domain reset release
  crt_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_syn_rst (
    .clk(syn_clk), .rst_n(rst_n), .d(1'b1), .q(syn_rst_n));
  crt_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n));

  // Main path controls into the synthesized-clock domain
  crt_sync #(.STAGES(SYNC_STAGES), .WIDTH(MW)) u_main_sync (
    .clk(syn_clk), .rst_n(syn_rst_n),
    .d({ratio_ok, pll_locked, unlock_pass, main_off}), .q(main_side_q));
  assign {valid_s, lock_s, ovr_s, moff_s} = main_side_q;

  assign main_en = clk_pass(valid_s, lock_s, ovr_s) & ~moff_s & main_oe_q;

  crt_clk_gate u_main_gate (.clk(syn_clk), .rst_n(syn_rst_n), .en(main_en),
                            .gclk(main_pin), .run(main_run), .busy(main_busy));

  always_ff @(posedge syn_clk or negedge syn_rst_n) begin
    if (!syn_rst_n) main_oe_q <= 1'b0;
    else            main_oe_q <= oe_next(main_oe_q, moff_s, main_busy);
  end
  assign main_oe = main_oe_q;

  // Auxiliary clock requests, resynchronized inside the path
  assign raw_pass     = clk_pass(ratio_ok, pll_locked, unlock_pass);
  assign want_ref_raw = (aux_src == AUX_SRC_REF) & ~aux_off & raw_pass;
  assign want_syn_raw = (aux_src == AUX_SRC_SYN) & ~aux_off & raw_pass;

  crt_aux_path #(.SYNC_STAGES(SYNC_STAGES)) u_aux (
    .ref_clk(ref_clk), .syn_clk(syn_clk),
    .ref_rst_n(ref_rst_n), .syn_rst_n(syn_rst_n),
    .want_ref_raw(want_ref_raw), .want_syn_raw(want_syn_raw),
    .aux_off(aux_off), .aux_clk(aux_clk), .aux_oe_q(aux_oe_q));

  assign ind = lock_indicator(ratio_ok, pll_locked, ind_open_drain);

  always_comb begin
    if (aux_src == AUX_SRC_IND) begin
      aux_pin = ind.pin;
      aux_oe  = ind.drive & ~aux_off;
    end else begin
      aux_pin = aux_clk;   // reserved code: both gates closed, drains low
      aux_oe  = aux_oe_q;
    end
  end

  // R3: a blanked main path produces no high phase
  a_r3_main_blank: assert property (@(negedge syn_clk) disable iff (!syn_rst_n)
    $past(!lock_s && !ovr_s) |-> !main_pin);

  // R1: nothing on the main path before a valid ratio
  a_r1_main_hold_invalid: assert property (@(negedge syn_clk) disable iff (!syn_rst_n)
    $past(!valid_s) |-> !main_pin);

  // R9: the main enable never drops inside a high pulse
  a_r9_main_oe_covers_pulse: assert property (@(negedge syn_clk) disable iff (!syn_rst_n)
    main_pin |-> main_oe);

  // R7: open-drain indicator never drives high
  a_r7_open_drain_low: assert property (@(posedge syn_clk) disable iff (!syn_rst_n)
    (aux_src == AUX_SRC_IND && ind_open_drain && aux_oe) |-> !aux_pin);
endmodule

// File: tb/crt_clk_router_test.sv
`timescale 1ns/1ps
module crt_clk_router_test;
  logic syn_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic pll_locked = 1'b1, ratio_ok = 1'b0, unlock_pass = 1'b0;
  logic main_off = 1'b0, aux_off = 1'b0, ind_open_drain = 1'b0;
  logic [1:0] aux_src = 2'b00;
  logic main_pin, main_oe, aux_pin, aux_oe;

  crt_clk_router uut (
    .syn_clk(syn_clk), .ref_clk(ref_clk), .rst_n(rst_n), .pll_locked(pll_locked),
    .ratio_ok(ratio_ok), .unlock_pass(unlock_pass), .main_off(main_off),
    .aux_off(aux_off), .aux_src(aux_src), .ind_open_drain(ind_open_drain),
    .main_pin(main_pin), .main_oe(main_oe), .aux_pin(aux_pin), .aux_oe(aux_oe));

  always #2 syn_clk = ~syn_clk;                       // 250 MHz
  initial begin #1.3; forever #5 ref_clk = ~ref_clk; end  // 100 MHz

  int  n_vec = 0, n_bad = 0;
  bit  settled = 0, mon_main = 0, mon_aux = 0, done = 0;
  int  main_rises = 0, aux_rises = 0;
  real t_mr = 0.0, t_mf = 0.0, t_ar = 0.0, t_af = 0.0;
  wire aux_seen = aux_pin & aux_oe;

  task automatic chk_bit(input logic act, input logic exp, input string tag, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $realtime);
    end
  endtask

  task automatic chk_range(input real act, input real lo, input real hi,
                           input string tag, input string what);
    n_vec++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f..%0.3f at %0t", tag, what, act, lo, hi, $realtime);
    end
  endtask

  // Behavioural reference model, compared on every synthesized clock
  always @(posedge syn_clk) begin
    #1;
    if (settled) begin
      chk_bit(main_oe, !main_off, "R4", "main_oe");
      if (!ratio_ok)                       chk_bit(main_pin, 1'b0, "R1", "main_pin");
      else if (main_off)                   chk_bit(main_pin, 1'b0, "R4", "main_pin");
      else if (!pll_locked && !unlock_pass) chk_bit(main_pin, 1'b0, "R3", "main_pin");
      if (aux_src == 2'b11) begin
        if (!ratio_ok) begin
          chk_bit(aux_pin, 1'b0, "R1", "aux_pin ind");
          chk_bit(aux_oe, !aux_off, "R4", "aux_oe ind");
        end else if (!ind_open_drain) begin
          chk_bit(aux_oe, !aux_off, "R6", "aux_oe push-pull");
          if (!aux_off) chk_bit(aux_pin, !pll_locked, "R6", "aux_pin push-pull");
        end else begin
          chk_bit(aux_oe, !aux_off && !pll_locked, "R7", "aux_oe open-drain");
          chk_bit(aux_pin, 1'b0, "R7", "aux_pin open-drain");
        end
      end else begin
        chk_bit(aux_oe, !aux_off, "R4", "aux_oe clock src");
        if (aux_src == 2'b01)                 chk_bit(aux_pin, 1'b0, "R8", "aux_pin reserved");
        else if (!ratio_ok)                   chk_bit(aux_pin, 1'b0, "R1", "aux_pin");
        else if (aux_off)                     chk_bit(aux_pin, 1'b0, "R4", "aux_pin");
        else if (!pll_locked && !unlock_pass) chk_bit(aux_pin, 1'b0, "R3", "aux_pin");
      end
    end
  end

  // Pulse-width monitors (R9)
  always @(posedge main_pin) begin
    main_rises++;
    if (mon_main) chk_range($realtime - t_mf, 1.95, 1.0e9, "R9", "main low interval");
    t_mr = $realtime;
  end
  always @(negedge main_pin) begin
    if (mon_main) chk_range($realtime - t_mr, 1.95, 2.05, "R9", "main high pulse");
    t_mf = $realtime;
  end
  always @(posedge aux_seen) begin
    aux_rises++;
    if (mon_aux) chk_range($realtime - t_af, 1.95, 1.0e9, "R9", "aux low interval");
    t_ar = $realtime;
  end
  always @(negedge aux_seen) begin
    if (mon_aux) begin
      real w;
      w = $realtime - t_ar;
      if (w > 3.5) chk_range(w, 4.95, 5.05, "R9", "aux high pulse (ref)");
      else         chk_range(w, 1.95, 2.05, "R9", "aux high pulse (syn)");
    end
    t_af = $realtime;
  end

  task automatic settle();
    settled = 0;
    repeat (60) @(posedge syn_clk);
    #1;
    settled = 1;
  endtask

  task automatic count_window(output int nm, output int na);
    int m0, a0;
    m0 = main_rises; a0 = aux_rises;
    #400;
    nm = main_rises - m0; na = aux_rises - a0;
  endtask

  task automatic aux_high_width(output real w);
    real t0;
    @(posedge aux_seen); t0 = $realtime;
    @(negedge aux_seen); w = $realtime - t0;
  endtask

  task automatic at_gap();
    @(posedge syn_clk); #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    int nm, na;
    real w;
    #51;
    chk_bit(main_pin, 1'b0, "R1", "main_pin in reset");
    chk_bit(aux_pin, 1'b0, "R1", "aux_pin in reset");
    at_gap(); rst_n = 1'b1;
    settle();
    count_window(nm, na);
    chk_range(nm, 0, 0, "R1", "main rises before valid ratio");
    chk_range(na, 0, 0, "R1", "aux rises before valid ratio");
    aux_src = 2'b11; settle();
    chk_bit(aux_pin, 1'b0, "R1", "indicator before valid ratio");
    aux_src = 2'b00; settle();

    at_gap(); ratio_ok = 1'b1; settle();
    mon_main = 1; mon_aux = 1;
    count_window(nm, na);
    chk_range(nm, 99, 101, "R2", "main rises, locked");
    chk_range(na, 39, 41, "R5", "aux rises, ref source");
    aux_high_width(w);
    chk_range(w, 4.95, 5.05, "R5", "aux pulse width, ref source");

    at_gap(); aux_src = 2'b10; settle();
    count_window(nm, na);
    chk_range(na, 99, 101, "R5", "aux rises, syn source");
    aux_high_width(w);
    chk_range(w, 1.95, 2.05, "R10", "aux pulse width after switch to syn");

    for (int k = 0; k < 6; k++) begin
      #(37.7 + 13.1 * k);
      aux_src = (aux_src == 2'b00) ? 2'b10 : 2'b00;
      settle();
      aux_high_width(w);
      if (aux_src == 2'b00) chk_range(w, 4.95, 5.05, "R10", "width after switch to ref");
      else                  chk_range(w, 1.95, 2.05, "R10", "width after switch to syn");
    end
    aux_src = 2'b10; settle();

    #3.4; pll_locked = 1'b0; settle();
    count_window(nm, na);
    chk_range(nm, 0, 0, "R3", "main rises while unlocked");
    chk_range(na, 0, 0, "R3", "aux rises while unlocked");
    #2.6; pll_locked = 1'b1; settle();
    count_window(nm, na);
    chk_range(nm, 99, 101, "R3", "main rises after relock");
    at_gap(); unlock_pass = 1'b1; settle();
    #1.7; pll_locked = 1'b0; settle();
    count_window(nm, na);
    chk_range(nm, 99, 101, "R3", "main rises unlocked with override");
    chk_range(na, 99, 101, "R3", "aux rises unlocked with override");
    at_gap(); pll_locked = 1'b1; unlock_pass = 1'b0; settle();

    #0.9; main_off = 1'b1; settle();
    chk_bit(main_oe, 1'b0, "R4", "main_oe disabled");
    #1.3; main_off = 1'b0; settle();
    count_window(nm, na);
    chk_range(nm, 99, 101, "R4", "main rises after re-enable");

    at_gap(); aux_src = 2'b00; settle();
    #2.2; aux_off = 1'b1; settle();
    chk_bit(aux_oe, 1'b0, "R4", "aux_oe disabled, ref source");
    #4.1; aux_off = 1'b0; settle();
    count_window(nm, na);
    chk_range(na, 39, 41, "R4", "aux rises after re-enable");

    mon_aux = 0;
    at_gap(); aux_src = 2'b11; ind_open_drain = 1'b0; settle();
    chk_bit(aux_pin, 1'b0, "R6", "push-pull locked");
    at_gap(); pll_locked = 1'b0; settle();
    chk_bit(aux_pin, 1'b1, "R6", "push-pull unlocked");
    at_gap(); ind_open_drain = 1'b1; settle();
    chk_bit(aux_oe, 1'b1, "R7", "open-drain unlocked drives");
    chk_bit(aux_pin, 1'b0, "R7", "open-drain unlocked low");
    at_gap(); pll_locked = 1'b1; settle();
    chk_bit(aux_oe, 1'b0, "R7", "open-drain locked floats");
    at_gap(); aux_off = 1'b1; settle();
    at_gap(); aux_off = 1'b0; ind_open_drain = 1'b0; pll_locked = 1'b0; settle();
    at_gap(); pll_locked = 1'b1; settle();

    at_gap(); aux_src = 2'b00; ind_open_drain = 1'b1; settle();
    mon_aux = 1;
    count_window(nm, na);
    chk_range(na, 39, 41, "R7", "open-drain bit ignored for ref source");
    chk_bit(aux_oe, 1'b1, "R7", "aux_oe with clock source");

    mon_aux = 0;
    at_gap(); aux_src = 2'b01; settle();
    count_window(nm, na);
    chk_range(na, 0, 0, "R8", "aux rises, reserved code");
    chk_bit(aux_pin, 1'b0, "R8", "aux_pin, reserved code");

    settled = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule